// File: doc/BRIEF.md
# Half to Single Precision Float Widener

This block converts a 16-bit binary floating-point value into the 32-bit binary floating-point value with the same numeric value. The conversion is exact for every non-NaN input, because the wider format holds every half-precision number as a normal number. The block sorts the input into one of five kinds: zero, subnormal, normal, infinity or NaN. It rebiases the exponent of normal values. It renormalizes subnormal values with a leading-zero count. It turns NaNs into quiet NaNs, or into one fixed canonical NaN when that mode is selected.

The unit is a single registered stage. A result and its invalid-operation flag appear on the cycle after an input is presented with `in_valid` high. When `in_valid` is low, the output register keeps its contents. A datapath uses it wherever half-precision operands feed single-precision arithmetic.

Top module: `half_to_single_widen`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `out_single` and `out_invalid` are all zero.
- R2: `out_valid` is high exactly on the cycle after a cycle where `in_valid` was high. The result for an input captured at a clock edge is visible after that same edge.
- R3: A half input with exponent field (bits 14:10) zero and fraction field (bits 9:0) zero gives a single-precision zero with the same sign in bit 31. An exponent of all ones with a zero fraction gives single-precision infinity (bits 30:23 all ones, bits 22:0 zero) with the same sign.
- R4: For a normal input (exponent 1 to 30), the output exponent is the input exponent plus 112. The output fraction is the input fraction in bits 22:13, with bits 12:0 zero.
- R5: For a subnormal input (exponent 0, fraction nonzero) with its highest set fraction bit at position p, the output is a normal number. Its exponent is 103+p, and the fraction bits below p are placed at the top of bits 22:0, with everything below them zero.
- R6: With `canon_nan_en` low, a NaN input (exponent all ones, fraction nonzero) keeps its sign and gives exponent all ones. Bit 22 is forced to one, input fraction bits 8:0 go to bits 21:13, and bits 12:0 are zero.
- R7: With `canon_nan_en` high, every NaN input gives 0x7FC00000.
- R8: A signalling NaN input (NaN with fraction bit 9 clear) sets `out_invalid` with its result, whatever the value of `canon_nan_en`.
- R9: `out_invalid` is low with the result of every quiet NaN and every non-NaN input.
- R10: On a cycle after which `in_valid` was low, `out_single` and `out_invalid` hold the values they had before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Captures `in_half` at this clock edge |
| in_half | input | 16 | Half-precision operand |
| canon_nan_en | input | 1 | Replace every NaN result with the canonical quiet NaN |
| out_valid | output | 1 | Result registered from the previous cycle's input |
| out_single | output | 32 | Single-precision result |
| out_invalid | output | 1 | Input was a signalling NaN |

## Verification
Subnormal inputs are the hardest case to cover. The leading-zero count and the shift have to agree for each of the ten possible positions of the leading one, and one wrong position only affects a small slice of encodings. Signalling NaNs with a one-bit payload under both NaN modes are similarly narrow. The stimulus therefore runs through every 16-bit encoding once with the canonical-NaN mode off and once with it on. It inserts idle cycles with garbage input every few hundred values to exercise the hold behaviour and the valid timing within the same stream.

// File: rtl/hw_fp_pkg.sv
package hw_fp_pkg;
  localparam int HALF_EXP_W = 5;
  localparam int HALF_FRC_W = 10;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRC_W  = 23;

  typedef enum logic [2:0] {
    FCL_ZERO = 3'd0,
    FCL_SUB  = 3'd1,
    FCL_NORM = 3'd2,
    FCL_INF  = 3'd3,
    FCL_NAN  = 3'd4
  } fp_class_e;
endpackage

// File: rtl/hw_fp_classify.sv
module hw_fp_classify
  import hw_fp_pkg::*;
#(
  parameter int EXP_W = HALF_EXP_W,
  parameter int FRC_W = HALF_FRC_W
) (
  input  logic [EXP_W-1:0] exp_field,
  input  logic [FRC_W-1:0] frc_field,
  output fp_class_e        kind,
  output logic             is_snan
);
  logic exp_zero, exp_ones, frc_zero;

  always_comb begin
    exp_zero = (exp_field == '0);
    exp_ones = (exp_field == '1);
    frc_zero = (frc_field == '0);
    if (exp_zero && frc_zero)      kind = FCL_ZERO;
    else if (exp_zero)             kind = FCL_SUB;
    else if (exp_ones && frc_zero) kind = FCL_INF;
    else if (exp_ones)             kind = FCL_NAN;
    else                           kind = FCL_NORM;
    is_snan = exp_ones && !frc_zero && !frc_field[FRC_W-1];
  end
endmodule

// File: rtl/hw_lead_zero.sv
module hw_lead_zero #(
  parameter int W  = 10,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] zeros
);
  logic [W-1:0] hit;

  // hit[i]: bit i is set and every bit above it is clear
  generate
    for (genvar i = 0; i < W; i++) begin : g_hit
      if (i == W - 1) begin : g_top
        assign hit[i] = vec[i];
      end else begin : g_low
        assign hit[i] = vec[i] && (vec[W-1:i+1] == '0);
      end
    end
  endgenerate

  always_comb begin
    zeros = CW'(W);
    for (int i = 0; i < W; i++) begin
      if (hit[i]) zeros = CW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/hw_widen_core.sv
module hw_widen_core
  import hw_fp_pkg::*;
#(
  parameter int EI = HALF_EXP_W,
  parameter int FI = HALF_FRC_W,
  parameter int EO = SGL_EXP_W,
  parameter int FO = SGL_FRC_W,
  localparam int IW = 1 + EI + FI,
  localparam int OW = 1 + EO + FO,
  localparam int PAD = FO - FI,
  localparam int REBIAS = ((1 << (EO - 1)) - 1) - ((1 << (EI - 1)) - 1),
  localparam int CW = $clog2(FI + 1)
) (
  input  logic [IW-1:0] src,
  input  logic          canon_nan,
  output logic [OW-1:0] dst,
  output logic          invalid
);
  logic          sgn;
  logic [EI-1:0] e_in;
  logic [FI-1:0] f_in;
  fp_class_e     kind;
  logic          snan;
  logic [CW-1:0] lz;
  logic [FI-1:0] f_shift;
  logic [FI-1:0] f_norm;

  assign sgn  = src[IW-1];
  assign e_in = src[IW-2 -: EI];
  assign f_in = src[FI-1:0];

  hw_fp_classify #(.EXP_W(EI), .FRC_W(FI)) u_cls (
    .exp_field (e_in),
    .frc_field (f_in),
    .kind      (kind),
    .is_snan   (snan)
  );

  hw_lead_zero #(.W(FI)) u_lz (
    .vec   (f_in),
    .zeros (lz)
  );

  // drop the leading one once it reaches the top bit
  always_comb begin
    f_shift = f_in << lz;
    f_norm  = {f_shift[FI-2:0], 1'b0};
  end

  always_comb begin
    invalid = snan;
    unique case (kind)
      FCL_ZERO: dst = {sgn, {(OW-1){1'b0}}};
      FCL_INF:  dst = {sgn, {EO{1'b1}}, {FO{1'b0}}};
      FCL_NORM: dst = {sgn, EO'(e_in) + EO'(REBIAS), f_in, {PAD{1'b0}}};
      FCL_SUB:  dst = {sgn, EO'(REBIAS) - EO'(lz), f_norm, {PAD{1'b0}}};
      FCL_NAN: begin
        if (canon_nan) dst = {1'b0, {EO{1'b1}}, 1'b1, {(FO-1){1'b0}}};
        else           dst = {sgn, {EO{1'b1}}, 1'b1, f_in[FI-2:0], {PAD{1'b0}}};
      end
      default:  dst = '0;
    endcase
  end
endmodule

// File: rtl/half_to_single_widen.sv
module half_to_single_widen
  import hw_fp_pkg::*;
#(
  parameter int EI = HALF_EXP_W,
  parameter int FI = HALF_FRC_W,
  parameter int EO = SGL_EXP_W,
  parameter int FO = SGL_FRC_W,
  localparam int IW = 1 + EI + FI,
  localparam int OW = 1 + EO + FO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [IW-1:0] in_half,
  input  logic          canon_nan_en,
  output logic          out_valid,
  output logic [OW-1:0] out_single,
  output logic          out_invalid
);
  logic [OW-1:0] core_dst;
  logic          core_inv;
  logic [OW-1:0] res_q, res_d;
  logic          inv_q, inv_d;
  logic          vld_q;

  hw_widen_core #(.EI(EI), .FI(FI), .EO(EO), .FO(FO)) u_core (
    .src       (in_half),
    .canon_nan (canon_nan_en),
    .dst       (core_dst),
    .invalid   (core_inv)
  );

  always_comb begin
    res_d = res_q;
    inv_d = inv_q;
    if (in_valid) begin
      res_d = core_dst;
      inv_d = core_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      inv_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      res_q <= res_d;
      inv_q <= inv_d;
      vld_q <= in_valid;
    end
  end

  assign out_valid   = vld_q;
  assign out_single  = res_q;
  assign out_invalid = inv_q;
endmodule

// File: rtl/hw_widen_chk.sv
module hw_widen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] in_half,
  input logic        canon_nan_en,
  input logic        out_valid,
  input logic [31:0] out_single,
  input logic        out_invalid
);
  logic i_nan, i_snan, i_zero;
  assign i_nan  = (in_half[14:10] == 5'h1f) && (in_half[9:0] != 10'd0);
  assign i_snan = i_nan && !in_half[9];
  assign i_zero = (in_half[14:0] == 15'd0);

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);                                          // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);                                        // R2
  AST_ZERO_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && i_zero) |=> (out_single == {$past(in_half[15]), 31'd0})); // R3
  AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && i_nan) |=> (out_single[30:22] == 9'h1ff));           // R6
  AST_CANON_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && i_nan && canon_nan_en) |=> (out_single == 32'h7fc00000)); // R7
  AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && i_snan) |=> out_invalid);                            // R8
  AST_NO_FALSE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !i_snan) |=> !out_invalid);                          // R9
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_single) && $stable(out_invalid)));     // R10
endmodule

bind half_to_single_widen hw_widen_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_half      (in_half),
  .canon_nan_en (canon_nan_en),
  .out_valid    (out_valid),
  .out_single   (out_single),
  .out_invalid  (out_invalid)
);

// File: tb/half_to_single_widen_tb.sv
module half_to_single_widen_tb;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [15:0] in_half;
  logic        canon_nan_en;
  logic        out_valid;
  logic [31:0] out_single;
  logic        out_invalid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  typedef struct {
    int          at;
    bit          vld;
    logic [31:0] s;
    bit          inv;
    logic [15:0] h;
    bit          dn;
  } item_t;
  item_t sb[$];
  logic [31:0] last_s;
  bit          last_inv;

  half_to_single_widen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_half      (in_half),
    .canon_nan_en (canon_nan_en),
    .out_valid    (out_valid),
    .out_single   (out_single),
    .out_invalid  (out_invalid)
  );

  initial clk = 0;
  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Behavioural model: result in [32:1], flag in [0]
  function automatic logic [32:0] model(input logic [15:0] h, input bit dn);
    int e = int'(h[14:10]);
    int m = int'(h[9:0]);
    int p;
    logic [31:0] r;
    bit inv = 0;
    if (e == 0 && m == 0) r = {h[15], 31'd0};
    else if (e == 31 && m == 0) r = {h[15], 8'hff, 23'd0};
    else if (e == 31) begin
      inv = (m < 512);
      if (dn) r = 32'h7fc00000;
      else    r = {h[15], 8'hff, 23'(((m | 512) << 13))};
    end else if (e == 0) begin
      p = 0;
      for (int k = 0; k < 10; k++) if ((m >> k) & 1) p = k;
      r = {h[15], 8'(103 + p), 23'((m - (1 << p)) << (23 - p))};
    end else r = {h[15], 8'(e + 112), 23'(m << 13)};
    return {r, inv};
  endfunction

  function automatic string tag(input logic [15:0] h, input bit dn);
    if (h[14:10] == 5'h1f && h[9:0] != 0) return dn ? "R7" : "R6";
    if (h[14:0] == 0 || h[14:0] == 15'h7c00) return "R3";
    if (h[14:10] == 0) return "R5";
    return "R4";
  endfunction

  task automatic drive(input bit v, input logic [15:0] h, input bit dn);
    logic [32:0] e;
    item_t it;
    @(negedge clk);
    in_valid = v; in_half = h; canon_nan_en = dn;
    e = model(h, dn);
    it.at = cyc; it.vld = v; it.s = e[32:1]; it.inv = e[0]; it.h = h; it.dn = dn;
    sb.push_back(it);
  endtask

  // Monitor: compares each item on the negedge after its capture edge
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at < cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (out_valid !== it.vld) begin
        errors++;
        $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, it.vld);
      end else if (it.vld) begin
        if (out_single !== it.s) begin
          errors++;
          $display("FAIL %s in %h dn %0b actual %h expected %h",
                   tag(it.h, it.dn), it.h, it.dn, out_single, it.s);
        end
        if (out_invalid !== it.inv) begin
          errors++;
          $display("FAIL %s in %h flag actual %0b expected %0b",
                   it.inv ? "R8" : "R9", it.h, out_invalid, it.inv);
        end
        last_s = it.s; last_inv = it.inv;
      end else if (out_single !== last_s || out_invalid !== last_inv) begin
        errors++;
        $display("FAIL R10 hold actual %h/%0b expected %h/%0b",
                 out_single, out_invalid, last_s, last_inv);
      end
    end
  end

  initial begin
    rst_n = 0; in_valid = 0; in_half = 16'h7c01; canon_nan_en = 0;
    last_s = '0; last_inv = 0;
    repeat (3) @(negedge clk);
    checks++; // R1
    if (out_valid !== 0 || out_single !== 0 || out_invalid !== 0) begin
      errors++;
      $display("FAIL R1 reset actual %0b/%h/%0b expected 0/00000000/0",
               out_valid, out_single, out_invalid);
    end
    rst_n = 1;
    // R2 R10: idle cycle with garbage input first
    drive(0, 16'hfdff, 1);
    for (int dn = 0; dn < 2; dn++) begin
      for (int x = 0; x < 65536; x++) begin
        drive(1, 16'(x), bit'(dn));
        if (x % 700 == 13) drive(0, 16'(x * 37 + 5), bit'(x & 1));
      end
    end
    drive(0, 16'h7d00, 0);
    drive(0, 16'h0001, 1);
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 %0d results never compared actual %0d expected 0", sb.size(), sb.size());
    end
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule